// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-line general-purpose I/O port attached to a plain byte-wide register bus made of an address, a write strobe, write data and read data. Each line can be set to input or output through a direction register. An output line drives its pad from an output data register, and the pad output enable follows the direction bit of that line.

The data register is reached through a window of addresses. Address bits 9 down to 2 act as a per-line mask, so one write or one read can touch any chosen subset of lines without a read-modify-write. A data write only changes lines that are both selected by the mask and currently outputs. A data read returns zero on unselected lines. On a selected line it returns the driven value if the line is an output, or the pad value after a two-flop synchronizer if the line is an input. Read data is registered.

Top module: `gpio_masked_port`

## Requirements
- R1: After synchronous reset, every line is an input: pad_oe and pad_out are 0, and a data read with all mask bits set returns 0 while all pads are low.
- R2: A write to address 0x400 loads the direction register (bit n = 1 makes line n an output, 0 an input). pad_oe equals the written value after that clock edge, and a read of 0x400 returns it.
- R3: A write to an address below 0x400 changes output data bit n only if address bit n+2 is 1; bits whose mask address bit is 0 keep their old value.
- R4: A data write has no effect on the output data bit of a line that is an input at the time of the write. A line switched to output later keeps its old output value until it is written again.
- R5: A read of an address below 0x400 returns 0 in every bit n whose address bit n+2 is 0, so a read of 1<<(n+2) returns line n's value in bit n alone.
- R6: A data read of an output line returns the value the block drives on pad_out, whatever the pad input shows.
- R7: A data read of an input line returns the pad input through a two-flop synchronizer. A pad change set up before clock edge k appears in read data after edge k+2.
- R8: pad_out bit n always equals output data bit n, and pad_oe bit n always equals direction bit n.
- R9: Writes to addresses at or above 0x400 other than the direction word (0x400 to 0x403) change nothing, and reads there return 0.
- R10: Read data is registered: the value for the address presented before a clock edge appears on bus_rdata right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 11 | Byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| pad_in | input | 8 | Asynchronous pad inputs |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
Direction and data writes take effect on pad_oe and pad_out one edge after the strobe. A read is due one edge after the address is presented, and a pad change reaches read data three edges after it is applied. The bench drives every input at the falling edge and updates its own behavioural model at the rising edge. It then compares all three outputs against that model at the next falling edge, so each result is checked in the cycle in which it is due. Directed reads add checks against fixed expected values, including the edge-by-edge progress of a pad change through the synchronizer.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Number of low address bits below the per-line mask bits.
  localparam int unsigned LANE_SHIFT = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } bus_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic [1:0]       warm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= pad_i;
      stage2_q <= stage1_q;
    end
  end

  // Counts edges since reset so the delay check never reaches into reset time.
  always_ff @(posedge clk) begin
    if (rst) warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assign sync_o = stage2_q;

  assert_sync_delay_R7: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd2) |=> (sync_o == $past(pad_i, 2)));
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_we,
  input  logic [WIDTH-1:0] dir_wdata,
  input  logic             data_we,
  input  logic [WIDTH-1:0] data_mask,
  input  logic [WIDTH-1:0] data_wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] odata_q
);
  // One slice per line: its direction bit and its output data bit.
  for (genvar n = 0; n < WIDTH; n++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        dir_q[n] <= 1'b0;
      end else if (dir_we) begin
        dir_q[n] <= dir_wdata[n];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        odata_q[n] <= 1'b0;
      end else if (data_we && data_mask[n] && dir_q[n]) begin
        odata_q[n] <= data_wdata[n];
      end
    end
  end

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
    dir_we |=> (dir_q == $past(dir_wdata)));

  assert_mask_keep_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((odata_q ^ $past(odata_q)) &
               ~($past(data_we) ? $past(data_mask) : {WIDTH{1'b0}})) == {WIDTH{1'b0}}));

  assert_input_hold_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((odata_q ^ $past(odata_q)) & ~$past(dir_q)) == {WIDTH{1'b0}}));
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  bus_sel_e         sel,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] odata,
  input  logic [WIDTH-1:0] insync,
  output logic [WIDTH-1:0] rdata_q
);
  logic [WIDTH-1:0] line_val;
  logic [WIDTH-1:0] rdata_d;

  for (genvar n = 0; n < WIDTH; n++) begin : g_val
    assign line_val[n] = dir[n] ? odata[n] : insync[n];
  end

  always_comb begin
    case (sel)
      SEL_DIR:  rdata_d = dir;
      SEL_DATA: rdata_d = line_val & mask;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  assert_unmasked_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_DATA) |=> ((rdata_q & ~$past(mask)) == {WIDTH{1'b0}}));

  assert_out_readback_R6: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_DATA) |=> (((rdata_q ^ $past(odata)) & $past(mask & dir)) == {WIDTH{1'b0}}));

  assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (rdata_q == {WIDTH{1'b0}}));
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned LINES  = 8,
  localparam int unsigned ADDR_W = LINES + LANE_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe
);
  // The direction word sits just above the data window.
  localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(1) << (LINES + LANE_SHIFT);
  localparam logic [ADDR_W-LANE_SHIFT-1:0] DIR_WORD = DIR_OFS[ADDR_W-1:LANE_SHIFT];

  bus_sel_e         sel;
  logic [LINES-1:0] mask;
  logic [LINES-1:0] dir_q;
  logic [LINES-1:0] odata_q;
  logic [LINES-1:0] insync;

  always_comb begin
    if (bus_addr < DIR_OFS)                                sel = SEL_DATA;
    else if (bus_addr[ADDR_W-1:LANE_SHIFT] == DIR_WORD)    sel = SEL_DIR;
    else                                                   sel = SEL_NONE;
  end

  assign mask = bus_addr[LANE_SHIFT +: LINES];

  gpio_in_sync #(.WIDTH(LINES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pad_i  (pad_in),
    .sync_o (insync)
  );

  gpio_pin_regs #(.WIDTH(LINES)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .dir_we     (bus_wr && (sel == SEL_DIR)),
    .dir_wdata  (bus_wdata),
    .data_we    (bus_wr && (sel == SEL_DATA)),
    .data_mask  (mask),
    .data_wdata (bus_wdata),
    .dir_q      (dir_q),
    .odata_q    (odata_q)
  );

  gpio_rd_mux #(.WIDTH(LINES)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .mask    (mask),
    .dir     (dir_q),
    .odata   (odata_q),
    .insync  (insync),
    .rdata_q (bus_rdata)
  );

  assign pad_out = odata_q;
  assign pad_oe  = dir_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (pad_oe == {LINES{1'b0}} && pad_out == {LINES{1'b0}}));

  assert_hole_write_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_NONE) |=> $stable(pad_oe) && $stable(pad_out));
endmodule

// File: tb/test_gpio_masked_port.sv
module test_gpio_masked_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // Behavioural model state.
  logic [7:0] m_dir, m_out, m_s1, m_s2, m_rd;

  gpio_masked_port i_gpio_masked_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    int a;
    a = int'(bus_addr);
    if (rst) begin
      m_dir = 0; m_out = 0; m_s1 = 0; m_s2 = 0; m_rd = 0;
    end else begin
      if (a < 1024) begin
        for (int i = 0; i < 8; i++)
          m_rd[i] = ((a >> (i + 2)) & 1) != 0 ? (m_dir[i] ? m_out[i] : m_s2[i]) : 1'b0;
      end else if ((a >> 2) == 256) begin
        m_rd = m_dir;
      end else begin
        m_rd = 0;
      end
      if (bus_wr) begin
        if (a < 1024) begin
          for (int i = 0; i < 8; i++)
            if ((((a >> (i + 2)) & 1) != 0) && m_dir[i]) m_out[i] = bus_wdata[i];
        end else if ((a >> 2) == 256) begin
          m_dir = bus_wdata;
        end
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R8", "pad_oe vs model", pad_oe, m_dir);
      check("R8", "pad_out vs model", pad_out, m_out);
      check(cur_req, "rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    bus_addr = a; bus_wr = 1'b0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R10 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;

    cur_req = "R1";
    check("R1", "pad_oe after reset", pad_oe, 8'h00);
    check("R1", "pad_out after reset", pad_out, 8'h00);
    rd(11'h3FC, v); check("R1", "data read after reset", v, 8'h00);

    cur_req = "R2";
    wr(11'h400, 8'hF0);
    check("R2", "pad_oe after dir write", pad_oe, 8'hF0);
    rd(11'h400, v); check("R2", "dir readback", v, 8'hF0);

    cur_req = "R3";
    wr(11'h3FC, 8'hFF);
    check("R4", "input lines ignore write", pad_out, 8'hF0);
    wr(11'h200, 8'h00);
    check("R3", "single-line write clears bit 7 only", pad_out, 8'h70);
    wr(11'h0C0, 8'h00);
    check("R3", "mask 0x30 write clears bits 4,5", pad_out, 8'h40);

    cur_req = "R4";
    wr(11'h400, 8'hFF);
    check("R4", "switch to output keeps old value", pad_out, 8'h40);
    wr(11'h3FC, 8'h0F);
    check("R4", "rewrite after switch", pad_out, 8'h0F);

    cur_req = "R5";
    rd(11'h004, v); check("R5", "read line 0 alone", v, 8'h01);
    rd(11'h200, v); check("R5", "read line 7 alone", v, 8'h00);
    rd(11'h03C, v); check("R5", "read mask 0x0F", v, 8'h0F);
    rd(11'h000, v); check("R5", "read empty mask", v, 8'h00);

    cur_req = "R6";
    wr(11'h400, 8'h0F);
    pad_in = 8'hA5;
    repeat (3) @(negedge clk);
    rd(11'h3FC, v); check("R6", "mixed read, outputs ignore pads", v, 8'hAF);

    cur_req = "R7";
    pad_in = 8'h00; bus_addr = 11'h3FC;
    @(negedge clk); check("R7", "pad change after 1 edge", bus_rdata, 8'hAF);
    @(negedge clk); check("R7", "pad change after 2 edges", bus_rdata, 8'hAF);
    @(negedge clk); check("R7", "pad change after 3 edges", bus_rdata, 8'h0F);

    cur_req = "R9";
    wr(11'h404, 8'hFF);
    check("R9", "write to hole keeps dir", pad_oe, 8'h0F);
    wr(11'h7FC, 8'h00);
    check("R9", "write to top hole keeps data", pad_out, 8'h0F);
    rd(11'h404, v); check("R9", "read of hole", v, 8'h00);

    cur_req = "R10";
    bus_addr = 11'h400;
    @(negedge clk); check("R10", "dir read one edge later", bus_rdata, 8'h0F);
    bus_addr = 11'h004;
    @(negedge clk); check("R10", "data read one edge later", bus_rdata, 8'h01);

    cur_req = "R3";
    for (int k = 0; k < 64; k++) begin
      pad_in = 8'(k * 37);
      wr(11'(k * 52 + 4), 8'(k * 91));
      if (k % 8 == 0) wr(11'h400, 8'(k * 13));
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    check("R1", "pad_oe after second reset", pad_oe, 8'h00);
    check("R1", "pad_out after second reset", pad_out, 8'h00);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule